// File: doc/BRIEF.md
# Event State Buffer Interrupt Source

This block holds a small array of interrupt sources. Each one carries a two-bit event state, pending (P) in bit 1 and queued (Q) in bit 0, plus an asserted flag that follows the input line of level-sensitive sources. Software and other agents change that state by loads and stores to a per-source address window. The address offset, not the data, selects the operation: trigger, end-of-interrupt, query, or force a state. When a state change means an event must be forwarded, the block sends the source number on a notification stream.

Each source owns a window of 2^WIN_SHIFT bytes, and WIN_SHIFT must be 12, 13, 16 or 17. With 13 or 17 the window splits in two halves. The lower half is a trigger page and the upper half is a management page. With 12 or 16 the single page does all operations. Input lines raise triggers on their rising edge. A parameter mask marks which sources are level-sensitive.

All three streams use valid/ready. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low while a response or a notification is still waiting to be taken. A held response or notification keeps its data stable until its ready input is high at an edge. Stores never produce a response, and every load produces exactly one.

Top module: `esb_irq_source`

## Requirements
- R1: After reset every source is in state 00, no asserted flag is set, `rsp_valid` and `ntf_valid` are low, and `req_ready` is high. State bit 1 is P and bit 0 is Q: 00 idle, 10 pending, 11 queued, 01 off.
- R2: The source index is `req_addr >> WIN_SHIFT`. With two-page layout (WIN_SHIFT 13 or 17), a store anywhere in the lower half triggers the source, and a load there returns all ones with no effect. The management page starts at window base + 2^(WIN_SHIFT-1). Offsets inside a page are decoded from address bits 11:8.
- R3: A trigger (a store at page offset 0x800) moves 00 to 10 and sends a notification. It moves 10 to 11 and leaves 11 and 01 unchanged. Only the 00 to 10 move notifies.
- R4: End-of-interrupt moves Q into P and clears Q, and it notifies when the new P is 1. A load at offset 0x000 does it and returns `rsp_data` = resulting P in bit 0, with zeros above. A store at offset 0x400 does it with no response.
- R5: A load at offset 0x800 returns {asserted, P, Q} in bits 2:0, with zeros above, and leaves the state unchanged.
- R6: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set the state to address bits 9:8 (00, 01, 10, 11). They return the previous {asserted, P, Q}.
- R7: On a level-sensitive source, the asserted flag equals the line level sampled at the previous clock edge. An end-of-interrupt while the flag is set re-triggers the source after the P/Q update, and the whole operation notifies at most once.
- R8: A rising edge on `irq_line[i]` triggers source i, on both level-sensitive and edge sources. A pending edge is served on a cycle with no accepted request and no held output, lowest index first.
- R9: An access to a source index at or beyond NUM_SRC changes no state and sends no notification. A load then returns all ones.
- R10: While `ntf_valid` or `rsp_valid` is waiting for its ready, the data stays stable and `req_ready` stays low.
- R11: A store at offset 0x000 or 0xC00 to 0xF00, and a load at offset 0x400, leave the state unchanged. Such loads return all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | WIN_SHIFT+IDX_BITS | Byte address in the block's range |
| rsp_valid | output | 1 | Load data available |
| rsp_ready | input | 1 | Load data taken |
| rsp_data | output | DATA_W | Load result |
| ntf_valid | output | 1 | Notification available |
| ntf_ready | input | 1 | Notification taken |
| ntf_src | output | IDX_BITS | Source number to forward |
| irq_line | input | NUM_SRC | Per-source interrupt input lines |

## Verification
Some properties are checked on every cycle. Held responses and notifications stay stable under back-pressure. Each new notification finds P set on its source. Out-of-range loads answer all ones, stores never answer, and a line edge is only dropped when it is served. The state-machine paths need the bench scenarios to show them, since they depend on history: trigger saturation at queued and off, end-of-interrupt with and without Q, forced states, the re-trigger of an asserted level source, the split page decode, and the accesses that must be ignored.

// File: rtl/esb_pkg.sv
`timescale 1ns/1ps
package esb_pkg;

  typedef logic [1:0] pq_t;

  localparam pq_t PQ_IDLE   = 2'b00;
  localparam pq_t PQ_OFF    = 2'b01;
  localparam pq_t PQ_PEND   = 2'b10;
  localparam pq_t PQ_QUEUED = 2'b11;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_EOI_LD,
    OP_EOI_ST,
    OP_GET,
    OP_SETPQ
  } op_e;

  typedef struct packed {
    pq_t  nxt;
    logic fire;
  } step_t;

  function automatic step_t pq_trigger(pq_t cur);
    step_t s;
    s.nxt  = cur;
    s.fire = 1'b0;
    if (cur == PQ_IDLE) begin
      s.nxt  = PQ_PEND;
      s.fire = 1'b1;
    end else if (cur == PQ_PEND) begin
      s.nxt = PQ_QUEUED;
    end
    return s;
  endfunction

  function automatic step_t pq_eoi(pq_t cur);
    step_t s;
    s.nxt  = {cur[0], 1'b0};
    s.fire = cur[0];
    return s;
  endfunction

endpackage

// File: rtl/esb_addr_decode.sv
`timescale 1ns/1ps
module esb_addr_decode #(
  parameter int WIN_SHIFT = 13,
  parameter int IDX_BITS  = 3,
  parameter int NUM_SRC   = 6,
  localparam int ADDR_W   = WIN_SHIFT + IDX_BITS
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                write,
  output logic [IDX_BITS-1:0] idx,
  output logic                in_range,
  output esb_pkg::op_e        op,
  output esb_pkg::pq_t        set_val
);
  import esb_pkg::*;

  localparam bit TWO_PAGE = (WIN_SHIFT == 13) || (WIN_SHIFT == 17);

  logic mgmt;
  logic unused_addr;

  assign unused_addr = ^addr;
  assign idx         = addr[ADDR_W-1:WIN_SHIFT];
  assign in_range    = (int'(idx) < NUM_SRC);
  assign set_val     = addr[9:8];

  generate
    if (TWO_PAGE) begin : g_split
      assign mgmt = addr[WIN_SHIFT-1];
    end else begin : g_single
      assign mgmt = 1'b1;
    end
  endgenerate

  always_comb begin
    op = OP_NONE;
    if (!mgmt) begin
      if (write) op = OP_TRIG;
    end else begin
      unique case (addr[11:10])
        2'b00: if (!write) op = OP_EOI_LD;
        2'b01: if (write)  op = OP_EOI_ST;
        2'b10: op = write ? OP_TRIG : OP_GET;
        default: if (!write) op = OP_SETPQ;
      endcase
    end
  end

endmodule

// File: rtl/esb_src_bank.sv
`timescale 1ns/1ps
module esb_src_bank #(
  parameter int NUM_SRC  = 6,
  parameter int IDX_BITS = 3,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       irq_line,
  input  logic                     wr_en,
  input  logic [IDX_BITS-1:0]      wr_idx,
  input  esb_pkg::pq_t             wr_pq,
  input  logic                     clr_en,
  input  logic [IDX_BITS-1:0]      clr_idx,
  output logic [NUM_SRC-1:0][1:0]  pq_o,
  output logic [NUM_SRC-1:0]       asserted_o,
  output logic [NUM_SRC-1:0]       edge_pend_o
);

  logic [NUM_SRC-1:0] line_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pq_o[i]        <= esb_pkg::PQ_IDLE;
        line_q[i]      <= 1'b0;
        edge_pend_o[i] <= 1'b0;
      end else begin
        line_q[i] <= irq_line[i];
        if (wr_en && wr_idx == IDX_BITS'(i)) pq_o[i] <= wr_pq;
        if (irq_line[i] && !line_q[i])
          edge_pend_o[i] <= 1'b1;
        else if (clr_en && clr_idx == IDX_BITS'(i))
          edge_pend_o[i] <= 1'b0;
      end
    end

    if (LEVEL_MASK[i]) begin : g_level
      assign asserted_o[i] = line_q[i];
    end else begin : g_edge
      assign asserted_o[i] = 1'b0;
    end

    // R8
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(edge_pend_o[i]) |-> $past(clr_en && clr_idx == IDX_BITS'(i)));
  end

endmodule

// File: rtl/esb_edge_pick.sv
`timescale 1ns/1ps
module esb_edge_pick #(
  parameter int NUM_SRC  = 6,
  parameter int IDX_BITS = 3
) (
  input  logic [NUM_SRC-1:0]  pend,
  output logic                any,
  output logic [IDX_BITS-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_BITS'(i);
    end
  end
  assign any = |pend;
endmodule

// File: rtl/esb_irq_source.sv
`timescale 1ns/1ps
module esb_irq_source #(
  parameter int WIN_SHIFT = 13,
  parameter int IDX_BITS  = 3,
  parameter int NUM_SRC   = 6,
  parameter int DATA_W    = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 6'b110000,
  localparam int ADDR_W   = WIN_SHIFT + IDX_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                ntf_valid,
  input  logic                ntf_ready,
  output logic [IDX_BITS-1:0] ntf_src,
  input  logic [NUM_SRC-1:0]  irq_line
);
  import esb_pkg::*;

  logic [IDX_BITS-1:0]      dec_idx;
  logic                     dec_in_range;
  op_e                      dec_op;
  pq_t                      dec_set;
  logic [NUM_SRC-1:0][1:0]  pq_vec;
  logic [NUM_SRC-1:0]       asr_vec;
  logic [NUM_SRC-1:0]       edge_pend;
  logic                     edge_any;
  logic [IDX_BITS-1:0]      edge_idx;

  logic                req_fire, svc_edge;
  op_e                 op_eff;
  logic [IDX_BITS-1:0] sel_idx;
  pq_t                 sel_pq, np;
  logic                sel_asr, sel_lvl, fire;
  step_t               st_a, st_b;
  logic [DATA_W-1:0]   ld_data;

  esb_addr_decode #(.WIN_SHIFT(WIN_SHIFT), .IDX_BITS(IDX_BITS), .NUM_SRC(NUM_SRC)) u_dec (
    .addr(req_addr), .write(req_write), .idx(dec_idx),
    .in_range(dec_in_range), .op(dec_op), .set_val(dec_set)
  );

  esb_edge_pick #(.NUM_SRC(NUM_SRC), .IDX_BITS(IDX_BITS)) u_pick (
    .pend(edge_pend), .any(edge_any), .idx(edge_idx)
  );

  assign req_ready = !rsp_valid && !ntf_valid;
  assign req_fire  = req_valid && req_ready;
  assign svc_edge  = req_ready && !req_fire && edge_any;
  assign sel_idx   = req_fire ? dec_idx : edge_idx;

  always_comb begin
    if (req_fire)      op_eff = dec_in_range ? dec_op : OP_NONE;
    else if (svc_edge) op_eff = OP_TRIG;
    else               op_eff = OP_NONE;
  end

  always_comb begin
    sel_pq  = PQ_IDLE;
    sel_asr = 1'b0;
    sel_lvl = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_idx == IDX_BITS'(i)) begin
        sel_pq  = pq_vec[i];
        sel_asr = asr_vec[i];
        sel_lvl = LEVEL_MASK[i];
      end
    end
  end

  always_comb begin
    np      = sel_pq;
    fire    = 1'b0;
    st_a    = '0;
    st_b    = '0;
    ld_data = '1;
    unique case (op_eff)
      OP_TRIG: begin
        st_a = pq_trigger(sel_pq);
        np   = st_a.nxt;
        fire = st_a.fire;
      end
      OP_EOI_LD, OP_EOI_ST: begin
        st_a = pq_eoi(sel_pq);
        np   = st_a.nxt;
        fire = st_a.fire;
        if (sel_lvl && sel_asr) begin
          st_b = pq_trigger(st_a.nxt);
          np   = st_b.nxt;
          fire = st_a.fire | st_b.fire;
        end
        ld_data = DATA_W'(np[1]);
      end
      OP_GET:   ld_data = DATA_W'({sel_asr, sel_pq});
      OP_SETPQ: begin
        np      = dec_set;
        ld_data = DATA_W'({sel_asr, sel_pq});
      end
      default: ;
    endcase
  end

  esb_src_bank #(.NUM_SRC(NUM_SRC), .IDX_BITS(IDX_BITS), .LEVEL_MASK(LEVEL_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
    .wr_en(op_eff != OP_NONE), .wr_idx(sel_idx), .wr_pq(np),
    .clr_en(svc_edge), .clr_idx(edge_idx),
    .pq_o(pq_vec), .asserted_o(asr_vec), .edge_pend_o(edge_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      ntf_valid <= 1'b0;
      ntf_src   <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (ntf_valid && ntf_ready) ntf_valid <= 1'b0;
      if (req_fire && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_data  <= ld_data;
      end
      if (fire) begin
        ntf_valid <= 1'b1;
        ntf_src   <= sel_idx;
      end
    end
  end

  // R10
  ntf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid && !ntf_ready |=> ntf_valid && $stable(ntf_src));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R3
  ntf_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ntf_valid) |-> pq_vec[ntf_src][1]);
  // R9
  oob_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !req_write && !dec_in_range |=> rsp_valid && rsp_data == '1);
  // R4
  store_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && req_write |=> !rsp_valid);

endmodule

// File: tb/test_esb_irq_source.sv
`timescale 1ns/1ps
module test_esb_irq_source;

  localparam int SH = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, rsp_valid, ntf_valid;
  logic        rsp_ready = 1'b1, ntf_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic [2:0]  ntf_src;
  logic [5:0]  irq_line = '0;

  int checks = 0, errors = 0;
  logic [1:0] m_pq [8];
  localparam logic [5:0] LVL = 6'b110000;

  logic [7:0] exp_rsp[$];
  string      rsp_tag[$];
  int         exp_ntf[$];

  always #2 clk = ~clk;

  esb_irq_source i_esb_irq_source (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .ntf_valid(ntf_valid),
    .ntf_ready(ntf_ready), .ntf_src(ntf_src), .irq_line(irq_line)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare outputs against scoreboard queues
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_rsp.size() == 0) chk("R4 unexpected response", rsp_data, 'hEE);
      else chk(rsp_tag.pop_front(), rsp_data, exp_rsp.pop_front());
    end
    if (rst_n && ntf_valid && ntf_ready) begin
      if (exp_ntf.size() == 0) chk("R3 unexpected notification", ntf_src, 'hEE);
      else chk("R3 notification source", ntf_src, exp_ntf.pop_front());
    end
  end

  function automatic void m_trig(int s);
    if (m_pq[s] == 2'b00) begin m_pq[s] = 2'b10; exp_ntf.push_back(s); end
    else if (m_pq[s] == 2'b10) m_pq[s] = 2'b11;
  endfunction

  function automatic logic m_asr(int s);
    return LVL[s] & irq_line[s];
  endfunction

  function automatic void m_eoi(int s);
    m_pq[s] = {m_pq[s][0], 1'b0};
    if (m_pq[s][1]) exp_ntf.push_back(s);
    if (m_asr(s)) m_trig(s);
  endfunction

  function automatic void want(logic [7:0] d, string tag);
    exp_rsp.push_back(d);
    rsp_tag.push_back(tag);
  endfunction

  task automatic bus(input bit wr, input int s, input bit mg, input logic [11:0] off, input string tag);
    logic [1:0] prev;
    while (!req_ready) begin @(posedge clk); #1; end
    if (s >= 6) begin
      if (!wr) want(8'hFF, tag);
    end else if (!mg) begin
      if (wr) m_trig(s); else want(8'hFF, tag);
    end else begin
      prev = m_pq[s];
      case (off[11:10])
        2'b00: if (wr) ; else begin m_eoi(s); want({7'd0, m_pq[s][1]}, tag); end
        2'b01: if (wr) m_eoi(s); else want(8'hFF, tag);
        2'b10: if (wr) m_trig(s); else want({5'd0, m_asr(s), prev}, tag);
        default: if (wr) ; else begin m_pq[s] = off[9:8]; want({5'd0, m_asr(s), prev}, tag); end
      endcase
    end
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = 16'((s << SH) | (mg ? 'h1000 : 0) | int'(off));
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic line(input int s, input bit v);
    if (v && !irq_line[s]) begin irq_line[s] = 1'b1; m_trig(s); end
    else irq_line[s] = v;
    idle(5);
  endtask

  initial begin
    fork
      begin
        for (int k = 0; k < 8; k++) m_pq[k] = 2'b00;
        idle(3); rst_n = 1'b1; idle(1);
        chk("R1 req_ready after reset", req_ready, 1);
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        chk("R1 ntf_valid after reset", ntf_valid, 0);
        bus(0, 0, 1, 12'h800, "R1 idle state read");
        bus(1, 0, 0, 12'h000, "R2");                 // R2 trigger page store
        bus(1, 0, 1, 12'h800, "R3");                 // R3 10 -> 11
        bus(0, 0, 1, 12'h800, "R5 queued read");
        bus(1, 0, 1, 12'h800, "R3");                 // R3 stays 11
        bus(0, 0, 1, 12'h800, "R3 queued saturates");
        bus(0, 0, 1, 12'h000, "R4 load eoi from queued");
        bus(1, 0, 1, 12'h400, "R4");                 // R4 store eoi -> 00
        bus(0, 0, 1, 12'h800, "R4 idle after store eoi");
        bus(0, 0, 1, 12'h000, "R4 load eoi from idle");
        bus(0, 3, 1, 12'hD00, "R6 set off");
        bus(1, 3, 1, 12'h800, "R3");                 // R3 off ignores trigger
        bus(0, 3, 1, 12'h800, "R3 off unchanged");
        bus(0, 3, 1, 12'hF00, "R6 set queued");
        bus(0, 3, 1, 12'hE00, "R6 set pending");
        bus(0, 3, 1, 12'hC00, "R6 set idle");
        bus(0, 3, 0, 12'h800, "R2 trigger page load ones");
        bus(1, 3, 1, 12'h000, "R11");                // R11 ignored store
        bus(1, 3, 1, 12'hE00, "R11");                // R11 ignored store
        bus(0, 3, 1, 12'h400, "R11 ignored load ones");
        bus(0, 3, 1, 12'h800, "R11 state unchanged");
        bus(0, 6, 1, 12'h800, "R9 out of range load");
        bus(1, 7, 1, 12'h800, "R9");                 // R9 no notification
        bus(0, 7, 1, 12'hE00, "R9 out of range set");
        line(4, 1);                                  // R8 R7 level rise
        bus(0, 4, 1, 12'h800, "R7 asserted and pending");
        bus(0, 4, 1, 12'h000, "R7 eoi retriggers");
        bus(0, 4, 1, 12'h800, "R7 pending after retrigger");
        line(4, 0);
        bus(0, 4, 1, 12'h800, "R7 asserted cleared");
        bus(1, 4, 1, 12'h400, "R7");
        bus(0, 4, 1, 12'h800, "R7 idle after eoi");
        line(1, 1); line(1, 0);                      // R8 edge source pulse
        bus(0, 1, 1, 12'h800, "R8 edge source pending");
        ntf_ready = 1'b0;
        bus(1, 2, 1, 12'h800, "R10");
        for (int k = 0; k < 3; k++) begin
          chk("R10 ntf held", ntf_valid, 1);
          chk("R10 ntf source stable", ntf_src, 2);
          chk("R10 req_ready low", req_ready, 0);
          idle(1);
        end
        ntf_ready = 1'b1;
        idle(1);
        rsp_ready = 1'b0;
        bus(0, 2, 1, 12'h800, "R10 response after stall");
        idle(2);
        chk("R10 rsp held", rsp_valid, 1);
        chk("R10 rsp data stable", rsp_data, 2);
        chk("R10 req_ready low on rsp", req_ready, 0);
        rsp_ready = 1'b1;
        idle(10);
        chk("R3 notification queue drained", exp_ntf.size(), 0);
        chk("R5 response queue drained", exp_rsp.size(), 0);
      end
      begin
        idle(5000);
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule